// File: doc/BRIEF.md
# Element-Packed Register Write Port

This block is the write side of a 128-entry, 64-bit integer register file. Data arrives as a single element of 8, 16, 32 or 64 bits. Its position is given by a base register number and an element index. In vector mode the element index becomes a byte offset from the start of the base register. The offset may run past the end of that register, and the element then lands in the next registers in order. Only the bytes the element covers are written; the other bytes of that register keep their values.

In scalar mode the element is widened to 64 bits, by sign or zero extension, and fills the whole base register. The element index plays no part in a scalar write.

A vector write that would land beyond the last register is refused and raises an error flag. Register 0 always reads as zero. A combinational read port is provided so that the stored contents can be observed.

Top module: `elem_reg_writer`

## Requirements
- R1: After reset every register reads 0 and `rangeErr` is low.
- R2: The width code `widSel` is encoded as 0 = 64 bits, 1 = 8 bits, 2 = 16 bits and 3 = 32 bits. A vector element has byte offset `elemIdx` × (width/8). It is stored in register `baseReg` + offset/8, starting at byte lane offset mod 8, where lane 0 is bits 7:0.
- R3: A vector write changes only the bytes the element covers. Every other byte of every register keeps its value.
- R4: A scalar write (`isVec`=0) replaces all 64 bits of `baseReg`, whatever the value of `elemIdx`.
- R5: A scalar element narrower than 64 bits is zero-extended when `signExt`=0. When `signExt`=1 it is sign-extended from its top bit.
- R6: A vector write whose target register number exceeds 127 sets `rangeErr` high in the same cycle as `wrEn`, and no register changes. A target of exactly 127 is legal.
- R7: Register 0 always reads 0. A write that targets it is discarded without raising `rangeErr`.
- R8: A write takes effect on the rising clock edge where `wrEn` is high. A read of the same register in that cycle returns the old contents.
- R9: Writing seven 32-bit vector elements at indices 0 to 6 fills the base register and the next two, plus bits 31:0 of the fourth. Bits 63:32 of the fourth register are left unchanged.
- R10: `rangeErr` is low whenever `wrEn` is low or the write is scalar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| baseReg | input | 7 | Base register number |
| elemIdx | input | 10 | Element index (vector mode) |
| widSel | input | 2 | Element width code |
| elemData | input | 64 | Element value, right-aligned |
| isVec | input | 1 | 1 = vector (packed) write, 0 = scalar write |
| signExt | input | 1 | Scalar extension: 1 = signed, 0 = unsigned |
| rdAddr | input | 7 | Read port register number |
| rdData | output | 64 | Read port data (combinational) |
| rangeErr | output | 1 | Out-of-range vector write, combinational |

## Verification
`rangeErr` is combinational, so it is due in the same cycle as the strobe. Register contents change at the rising edge that takes the write and appear on the read port from then on. Inputs are driven on the falling edge and all checks sample 1 ns later. Before the edge, each write checks the read port against the old model contents and checks `rangeErr` against the predicted value. The model is updated only after the edge, so the next cycle's check sees the new data. Full sweeps of the read port compare every register against the model after each group of writes.

// File: rtl/elemwr_pkg.sv
package elemwr_pkg;
  localparam int XLEN  = 64;
  localparam int LANES = XLEN / 8;
  localparam int LANEW = $clog2(LANES);

  typedef enum logic [1:0] {
    WID_FULL = 2'd0,
    WID_B    = 2'd1,
    WID_H    = 2'd2,
    WID_W    = 2'd3
  } widCode_e;

  typedef struct packed {
    logic             commit;
    logic [LANES-1:0] byteEn;
    logic [LANEW-1:0] lane;
  } wrStrobe_t;
endpackage

// File: rtl/elemwr_ctrl.sv
module elemwr_ctrl
  import elemwr_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int IDXW     = 10,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input  logic            wrEn,
  input  logic [RW-1:0]   baseReg,
  input  logic [IDXW-1:0] elemIdx,
  input  widCode_e        widSel,
  input  logic            isVec,
  output wrStrobe_t       strobe,
  output logic [RW-1:0]   target,
  output logic            rangeErr
);
  localparam int OFFW = IDXW + LANEW;
  localparam int SUMW = ((IDXW > RW) ? IDXW : RW) + 1;

  logic [1:0]       sizeLog;
  logic [OFFW-1:0]  byteOff;
  logic [SUMW-1:0]  regSum;
  logic [LANES-1:0] elemMask;
  logic             beyond;

  always_comb begin
    unique case (widSel)
      WID_B:   begin sizeLog = 2'd0; elemMask = 8'h01; end
      WID_H:   begin sizeLog = 2'd1; elemMask = 8'h03; end
      WID_W:   begin sizeLog = 2'd2; elemMask = 8'h0F; end
      default: begin sizeLog = 2'd3; elemMask = 8'hFF; end
    endcase
    byteOff = OFFW'(elemIdx) << sizeLog;
    regSum  = SUMW'(baseReg) + SUMW'(byteOff[OFFW-1:LANEW]);
    beyond  = regSum > SUMW'(NUM_REGS - 1);

    rangeErr      = wrEn && isVec && beyond;
    target        = isVec ? regSum[RW-1:0] : baseReg;
    strobe.lane   = isVec ? byteOff[LANEW-1:0] : '0;
    strobe.byteEn = isVec ? (elemMask << strobe.lane) : '1;
    strobe.commit = wrEn && !rangeErr && (target != '0);
  end
endmodule

// File: rtl/elemwr_data.sv
module elemwr_data
  import elemwr_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobe_t       strobe,
  input  logic [RW-1:0]   target,
  input  logic [XLEN-1:0] elemData,
  input  widCode_e        widSel,
  input  logic            isVec,
  input  logic            signExt,
  input  logic [RW-1:0]   rdAddr,
  output logic [XLEN-1:0] rdData
);
  logic [XLEN-1:0] rowQ [NUM_REGS];
  logic [XLEN-1:0] narrow, widened, laneWord, wrWord;
  logic            fill;

  always_comb begin
    unique case (widSel)
      WID_B: begin
        fill    = signExt & elemData[7];
        narrow  = {56'b0, elemData[7:0]};
        widened = {{56{fill}}, elemData[7:0]};
      end
      WID_H: begin
        fill    = signExt & elemData[15];
        narrow  = {48'b0, elemData[15:0]};
        widened = {{48{fill}}, elemData[15:0]};
      end
      WID_W: begin
        fill    = signExt & elemData[31];
        narrow  = {32'b0, elemData[31:0]};
        widened = {{32{fill}}, elemData[31:0]};
      end
      default: begin
        fill    = 1'b0;
        narrow  = elemData;
        widened = elemData;
      end
    endcase
    laneWord = narrow << {strobe.lane, 3'b000};
    wrWord   = isVec ? laneWord : widened;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    if (r == 0) begin : g_zero
      assign rowQ[r] = '0;
    end else begin : g_live
      logic hit;
      assign hit = strobe.commit && (target == RW'(r));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rowQ[r] <= '0;
        end else if (hit) begin
          for (int b = 0; b < LANES; b++) begin
            if (strobe.byteEn[b]) rowQ[r][b*8 +: 8] <= wrWord[b*8 +: 8];
          end
        end
      end
    end
  end

  assign rdData = rowQ[rdAddr];
endmodule

// File: rtl/elem_reg_writer.sv
module elem_reg_writer
  import elemwr_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int IDXW     = 10,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [RW-1:0]   baseReg,
  input  logic [IDXW-1:0] elemIdx,
  input  logic [1:0]      widSel,
  input  logic [XLEN-1:0] elemData,
  input  logic            isVec,
  input  logic            signExt,
  input  logic [RW-1:0]   rdAddr,
  output logic [XLEN-1:0] rdData,
  output logic            rangeErr
);
  wrStrobe_t     strobe;
  logic [RW-1:0] target;
  widCode_e      widCode;

  assign widCode = widCode_e'(widSel);

  elemwr_ctrl #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_ctrl (
    .wrEn(wrEn), .baseReg(baseReg), .elemIdx(elemIdx), .widSel(widCode),
    .isVec(isVec), .strobe(strobe), .target(target), .rangeErr(rangeErr)
  );

  elemwr_data #(.NUM_REGS(NUM_REGS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .target(target),
    .elemData(elemData), .widSel(widCode), .isVec(isVec), .signExt(signExt),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/elemwr_checker.sv
module elemwr_checker #(
  parameter int NUM_REGS = 128,
  parameter int IDXW     = 10,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [RW-1:0]   baseReg,
  input logic [IDXW-1:0] elemIdx,
  input logic [1:0]      widSel,
  input logic            isVec,
  input logic            signExt,
  input logic [RW-1:0]   rdAddr,
  input logic [63:0]     rdData,
  input logic            rangeErr
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  p_err_needs_vec_r10: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> (wrEn && isVec));

  p_reg0_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == '0) |-> (rdData == 64'd0));

  p_err_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rangeErr) && rdAddr == $past(rdAddr))
      |-> rdData == $past(rdData));

  p_vec_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(wrEn && isVec && widSel == 2'd1 && elemIdx == '0 &&
                        baseReg == rdAddr) && rdAddr == $past(rdAddr))
      |-> rdData[63:8] == $past(rdData[63:8]));

  p_scalar_zext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(wrEn && !isVec && !signExt && widSel == 2'd1 &&
                        baseReg == rdAddr) && rdAddr == $past(rdAddr))
      |-> rdData[63:8] == 56'd0);
endmodule

bind elem_reg_writer elemwr_checker #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .baseReg(baseReg), .elemIdx(elemIdx),
  .widSel(widSel), .isVec(isVec), .signExt(signExt), .rdAddr(rdAddr),
  .rdData(rdData), .rangeErr(rangeErr)
);

// File: tb/sim_elem_reg_writer.sv
`timescale 1ns/1ps
module sim_elem_reg_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  baseReg = '0;
  logic [9:0]  elemIdx = '0;
  logic [1:0]  widSel = '0;
  logic [63:0] elemData = '0;
  logic        isVec = 1'b0;
  logic        signExt = 1'b0;
  logic [6:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic        rangeErr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [63:0] model [128];

  always #2.5 clk = ~clk;

  elem_reg_writer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .baseReg(baseReg), .elemIdx(elemIdx),
    .widSel(widSel), .elemData(elemData), .isVec(isVec), .signExt(signExt),
    .rdAddr(rdAddr), .rdData(rdData), .rangeErr(rangeErr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 128; r++) begin
      @(negedge clk);
      wrEn = 1'b0;
      rdAddr = 7'(r);
      #1;
      check(req, rdData, model[r]);
      check("R10", {63'd0, rangeErr}, 64'd0);
    end
  endtask

  // One write cycle: predicts error and new contents from the requirements.
  task automatic step(input int base, input int idx, input int wid,
                      input logic [63:0] data, input bit vec, input bit sx,
                      input string req);
    int nb, off, tgt, lane;
    bit expErr;
    logic [63:0] val;
    nb   = (wid == 0) ? 8 : (wid == 1) ? 1 : (wid == 2) ? 2 : 4;
    off  = idx * nb;
    tgt  = vec ? base + off / 8 : base;
    lane = vec ? off % 8 : 0;
    expErr = vec && (tgt > 127);
    @(negedge clk);
    wrEn = 1'b1; baseReg = 7'(base); elemIdx = 10'(idx); widSel = 2'(wid);
    elemData = data; isVec = vec; signExt = sx;
    rdAddr = (tgt <= 127) ? 7'(tgt) : 7'(base);
    #1;
    check({req, "/R8 old data"}, rdData, model[rdAddr]);
    check({req, " err"}, {63'd0, rangeErr}, {63'd0, expErr});
    @(posedge clk);
    if (!expErr && tgt != 0) begin
      if (vec) begin
        for (int k = 0; k < nb; k++) model[tgt][(lane + k) * 8 +: 8] = data[k * 8 +: 8];
      end else begin
        val = data;
        if (nb < 8) begin
          for (int bit_i = nb * 8; bit_i < 64; bit_i++) val[bit_i] = sx ? data[nb * 8 - 1] : 1'b0;
        end
        model[tgt] = val;
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check({req, " after edge"}, rdData, model[rdAddr]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int r = 0; r < 128; r++) model[r] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 err in reset", {63'd0, rangeErr}, 64'd0);
    rstN = 1'b1;
    sweep("R1 reset contents");

    // R4: scalar full writes with index ignored
    for (int r = 1; r < 16; r++)
      step(r, 5 * r, 0, {32'hA5A5_0000 + 32'(r), 32'h1234_5678 ^ 32'(r)}, 1'b0, 1'b0, "R4");
    step(120, 300, 0, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0, "R4/R10");

    // R3: three bytes into reg 5, bits 63:24 kept
    for (int i = 0; i < 3; i++) step(5, i, 1, 64'hFFFF_FFFF_FFFF_FF10 + 64'(i), 1'b1, 1'b0, "R3");

    // R9: seven 32-bit elements from reg 8
    for (int i = 0; i < 7; i++) step(8, i, 3, 64'hFFFF_FFFF_C000_0000 + 64'(i), 1'b1, 1'b0, "R9");
    @(negedge clk); rdAddr = 7'd11; #1;
    check("R9 upper half kept", {32'd0, rdData[63:32]}, {32'd0, 32'hA5A5_000B});

    // R2: 16-bit index 9 from reg 2 -> reg 4 lane 2; 8-bit spill far
    step(2, 9, 2, 64'h0000_0000_0000_BEEF, 1'b1, 1'b0, "R2");
    step(1, 100, 1, 64'h0000_0000_0000_0077, 1'b1, 1'b0, "R2 spill");

    // R5: scalar extension
    step(20, 0, 1, 64'h0000_0000_0000_0080, 1'b0, 1'b1, "R5 sext8");
    step(21, 0, 1, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 1'b0, "R5 zext8");
    step(22, 0, 2, 64'h0000_0000_0000_8001, 1'b0, 1'b1, "R5 sext16");
    step(23, 0, 3, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, "R5 sext32 pos");

    // R6: out of range and boundary
    step(127, 1, 0, 64'h1111_2222_3333_4444, 1'b1, 1'b0, "R6 oob64");
    step(120, 64, 1, 64'h55, 1'b1, 1'b0, "R6 oob8");
    step(127, 7, 1, 64'h66, 1'b1, 1'b0, "R6 edge ok");
    step(0, 1023, 3, 64'h99, 1'b1, 1'b0, "R6 far");

    // R7: register 0
    step(0, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0, 1'b0, "R7 scalar");
    step(0, 3, 1, 64'hAB, 1'b1, 1'b0, "R7 vector");

    sweep("R2/R3/R9 contents");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule